// File: doc/BRIEF.md
# CPU Halt and Wake Controller

This block holds a small processor core in a low-power halt state and decides how the core resumes. A one-cycle halt request from the instruction decoder moves it from running into halt, where it drops only the CPU clock enable; the oscillator and the peripheral clocks are never touched by it. While halted it watches two non-maskable sources (an external pin and a watchdog interrupt), eight external and eight peripheral maskable request lines with a mask bit and a 3-bit priority each, the level of the interrupt currently in service, and the global interrupt-enable flag.

Waking and acknowledging are separate decisions. Any non-maskable request or any unmasked maskable request ends halt, whatever its priority. The block then spends one cycle in a wake state, where it tells the core either to branch to a handler (with an acknowledge strobe and the index of the request taken) or to resume at the next instruction, leaving a request that cannot be serviced pending at its source. Any of the reset sources forces the block back to running with the clock enable high.

Top module: `halt_wake_ctrl`

## Requirements
- R1: When `halt_req_i` is high in the running state, `cpu_clk_en_o` is low from the next cycle on, and it is low only while halted.
- R2: While halted with no non-maskable request and no unmasked maskable request, the block stays halted; a request whose mask bit is 1 does not wake it.
- R3: A wake source seen while halted gives, one cycle later, `cpu_clk_en_o` high together with exactly one of `branch_o` or `resume_o` for one cycle; the cycle after that all pulses are low and the block runs.
- R4: A wake by `nmi_pin_i` or `wdt_irq_i` gives `branch_o`, `ack_o` and `ack_nmi_o` high with `ack_idx_o` = 0, regardless of the interrupt-enable flag, the in-service level and any maskable request.
- R5: A maskable wake with interrupts enabled and a priority number strictly below the in-service level gives `branch_o` and `ack_o`, with `ack_idx_o` the request index: external line k is index k, peripheral line k is index 8+k.
- R6: A maskable wake whose priority number is equal to or above the in-service level gives `resume_o` only, with `ack_o` low and `ack_idx_o` = 0.
- R7: A maskable wake while interrupts are disabled gives `resume_o` only, with no acknowledge, even when its priority is above the in-service level.
- R8: Among several unmasked requests the one with the smallest priority number is chosen (0 is highest); equal numbers go to the lower index.
- R9: With nothing in service the comparison level is 8, so a request of priority 7 is acknowledged.
- R10: If an unmasked request is already present when the halt request arrives, the block is halted for exactly one cycle and then wakes.
- R11: A low `rst_n_i` or any bit of `rst_src_i` at once forces the running state with `cpu_clk_en_o` high and all pulses low; normal operation resumes two clock edges after all reset sources are released.
- R12: `halt_req_i` has no effect while halted or in the wake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n_i | input | 1 | Reset pin, active low, asynchronous assert |
| rst_src_i | input | 3 | Further reset sources (watchdog reset, low-voltage detect, clock-monitor fault), active high |
| halt_req_i | input | 1 | One-cycle halt request from the decoder |
| nmi_pin_i | input | 1 | External non-maskable request |
| wdt_irq_i | input | 1 | Watchdog non-maskable interrupt |
| ext_req_i | input | 8 | External maskable request lines |
| ext_mask_i | input | 8 | Mask bits for external lines, 1 = masked |
| ext_prio_i | input | 24 | 3-bit priority per external line, line k at bits 3k+2..3k |
| per_req_i | input | 8 | Peripheral maskable request lines |
| per_mask_i | input | 8 | Mask bits for peripheral lines, 1 = masked |
| per_prio_i | input | 24 | 3-bit priority per peripheral line, line k at bits 3k+2..3k |
| in_service_i | input | 1 | An interrupt is currently being serviced |
| in_service_lvl_i | input | 3 | Priority of the interrupt in service |
| int_en_i | input | 1 | Global interrupt-enable flag |
| cpu_clk_en_o | output | 1 | CPU clock enable, low only in halt |
| branch_o | output | 1 | One-cycle pulse: branch to handler |
| resume_o | output | 1 | One-cycle pulse: continue with next instruction |
| ack_o | output | 1 | Acknowledge strobe for the taken request |
| ack_nmi_o | output | 1 | Taken request is non-maskable |
| ack_idx_o | output | 4 | Index of the acknowledged maskable request |

## Verification
The bound checker watches, on every cycle, that a halt request in the running state drops the clock enable, that halt holds without a wake source, that every wake yields exactly one of the two pulses for a single cycle before running again, that a non-maskable source always branches, and that a halt request during the wake cycle is ignored. Which request gets acknowledged, how the in-service level and the enable flag turn a wake into a resume, the index reported, the idle level of 8, the already-pending case and the reset behaviour depend on input values that only the bench's scenarios set up and compare against computed results.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_WAKE = 2'd2
   } hwc_state_e;

   typedef struct packed {
      logic branch;
      logic nmi;
   } hwc_verdict_t;

endpackage

// File: rtl/hwc_rst_sync.sv
module hwc_rst_sync #(
   parameter int STAGES  = 2,
   parameter int SRC_CNT = 3
) (
   input  logic               clk,
   input  logic               pin_n_i,
   input  logic [SRC_CNT-1:0] src_i,
   output logic               rst_n_o
);

   logic raw_n;
   logic [STAGES-1:0] chain_q;

   assign raw_n = pin_n_i & ~(|src_i);

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge raw_n) begin
            if (!raw_n) chain_q <= '0;
            else        chain_q <= 1'b1;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge raw_n) begin
            if (!raw_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/hwc_req_eval.sv
module hwc_req_eval #(
   parameter int N      = 16,
   parameter int PRIO_W = 3,
   parameter int IDX_W  = 4
) (
   input  logic [N-1:0]        req_i,
   input  logic [N-1:0]        mask_i,
   input  logic [N*PRIO_W-1:0] prio_i,
   output logic                any_o,
   output logic [IDX_W-1:0]    idx_o,
   output logic [PRIO_W-1:0]   prio_o
);

   logic [N-1:0]      elig;
   logic [PRIO_W-1:0] prio_arr [N];

   generate
      for (genvar g = 0; g < N; g++) begin : g_req
         assign elig[g]     = req_i[g] & ~mask_i[g];
         assign prio_arr[g] = prio_i[g*PRIO_W +: PRIO_W];
      end
   endgenerate

   always_comb begin
      any_o  = 1'b0;
      idx_o  = '0;
      prio_o = '1;
      for (int i = 0; i < N; i++) begin
         if (elig[i] && (!any_o || (prio_arr[i] < prio_o))) begin
            any_o  = 1'b1;
            idx_o  = IDX_W'(i);
            prio_o = prio_arr[i];
         end
      end
   end

endmodule

// File: rtl/hwc_fsm.sv
module hwc_fsm
   import hwc_pkg::*;
#(
   parameter int PRIO_W = 3,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_req_i,
   input  logic              nmi_i,
   input  logic              mask_any_i,
   input  logic [IDX_W-1:0]  mask_idx_i,
   input  logic [PRIO_W-1:0] mask_prio_i,
   input  logic              in_service_i,
   input  logic [PRIO_W-1:0] in_service_lvl_i,
   input  logic              int_en_i,
   output logic              cpu_clk_en_o,
   output logic              branch_o,
   output logic              resume_o,
   output logic              ack_nmi_o,
   output logic [IDX_W-1:0]  ack_idx_o
);

   localparam int LVL_W = PRIO_W + 1;
   localparam logic [LVL_W-1:0] IDLE_LVL = {1'b1, {PRIO_W{1'b0}}};

   hwc_state_e       state_q, state_d;
   hwc_verdict_t     verdict_d, verdict_q;
   logic [IDX_W-1:0] idx_d, idx_q;
   logic [LVL_W-1:0] cur_lvl;
   logic             above;
   logic             wake;

   assign cur_lvl = in_service_i ? {1'b0, in_service_lvl_i} : IDLE_LVL;
   assign above   = ({1'b0, mask_prio_i} < cur_lvl);
   assign wake    = nmi_i | mask_any_i;

   always_comb begin
      verdict_d.nmi    = nmi_i;
      verdict_d.branch = nmi_i | (mask_any_i & above & int_en_i);
      idx_d            = (verdict_d.branch && !nmi_i) ? mask_idx_i : '0;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:  if (halt_req_i) state_d = ST_HALT;
         ST_HALT: if (wake)       state_d = ST_WAKE;
         ST_WAKE:                 state_d = ST_RUN;
         default:                 state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN;
         verdict_q <= '0;
         idx_q     <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_HALT && wake) begin
            verdict_q <= verdict_d;
            idx_q     <= idx_d;
         end
      end
   end

   assign cpu_clk_en_o = (state_q != ST_HALT);
   assign branch_o     = (state_q == ST_WAKE) &  verdict_q.branch;
   assign resume_o     = (state_q == ST_WAKE) & ~verdict_q.branch;
   assign ack_nmi_o    = (state_q == ST_WAKE) &  verdict_q.nmi;
   assign ack_idx_o    = (state_q == ST_WAKE) ? idx_q : '0;

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
   parameter int NUM_EXT     = 8,
   parameter int NUM_PERIPH  = 8,
   parameter int PRIO_W      = 3,
   parameter int NUM_RST     = 3,
   parameter int SYNC_STAGES = 2,
   localparam int N     = NUM_EXT + NUM_PERIPH,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n_i,
   input  logic [NUM_RST-1:0]         rst_src_i,
   input  logic                       halt_req_i,
   input  logic                       nmi_pin_i,
   input  logic                       wdt_irq_i,
   input  logic [NUM_EXT-1:0]         ext_req_i,
   input  logic [NUM_EXT-1:0]         ext_mask_i,
   input  logic [NUM_EXT*PRIO_W-1:0]  ext_prio_i,
   input  logic [NUM_PERIPH-1:0]      per_req_i,
   input  logic [NUM_PERIPH-1:0]      per_mask_i,
   input  logic [NUM_PERIPH*PRIO_W-1:0] per_prio_i,
   input  logic                       in_service_i,
   input  logic [PRIO_W-1:0]          in_service_lvl_i,
   input  logic                       int_en_i,
   output logic                       cpu_clk_en_o,
   output logic                       branch_o,
   output logic                       resume_o,
   output logic                       ack_o,
   output logic                       ack_nmi_o,
   output logic [IDX_W-1:0]           ack_idx_o
);

   generate
      if (NUM_EXT < 1 || NUM_PERIPH < 1) begin : g_bad_count
         $error("halt_wake_ctrl: each request group needs at least one line");
      end
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
         $error("halt_wake_ctrl: PRIO_W must be 1..8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("halt_wake_ctrl: SYNC_STAGES must be at least 1");
      end
      if (NUM_RST < 1) begin : g_bad_rst
         $error("halt_wake_ctrl: NUM_RST must be at least 1");
      end
   endgenerate

   logic                rst_int_n;
   logic [N-1:0]        all_req;
   logic [N-1:0]        all_mask;
   logic [N*PRIO_W-1:0] all_prio;
   logic                nmi_any;
   logic                m_any;
   logic [IDX_W-1:0]    m_idx;
   logic [PRIO_W-1:0]   m_prio;

   assign all_req  = {per_req_i,  ext_req_i};
   assign all_mask = {per_mask_i, ext_mask_i};
   assign all_prio = {per_prio_i, ext_prio_i};
   assign nmi_any  = nmi_pin_i | wdt_irq_i;

   hwc_rst_sync #(
      .STAGES  (SYNC_STAGES),
      .SRC_CNT (NUM_RST)
   ) u_rst (
      .clk     (clk),
      .pin_n_i (rst_n_i),
      .src_i   (rst_src_i),
      .rst_n_o (rst_int_n)
   );

   hwc_req_eval #(
      .N      (N),
      .PRIO_W (PRIO_W),
      .IDX_W  (IDX_W)
   ) u_eval (
      .req_i  (all_req),
      .mask_i (all_mask),
      .prio_i (all_prio),
      .any_o  (m_any),
      .idx_o  (m_idx),
      .prio_o (m_prio)
   );

   hwc_fsm #(
      .PRIO_W (PRIO_W),
      .IDX_W  (IDX_W)
   ) u_fsm (
      .clk              (clk),
      .rst_n            (rst_int_n),
      .halt_req_i       (halt_req_i),
      .nmi_i            (nmi_any),
      .mask_any_i       (m_any),
      .mask_idx_i       (m_idx),
      .mask_prio_i      (m_prio),
      .in_service_i     (in_service_i),
      .in_service_lvl_i (in_service_lvl_i),
      .int_en_i         (int_en_i),
      .cpu_clk_en_o     (cpu_clk_en_o),
      .branch_o         (branch_o),
      .resume_o         (resume_o),
      .ack_nmi_o        (ack_nmi_o),
      .ack_idx_o        (ack_idx_o)
   );

   assign ack_o = branch_o;

endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
   parameter int N = 16
) (
   input logic         clk,
   input logic         rst_int_n,
   input logic         halt_req_i,
   input logic         nmi_pin_i,
   input logic         wdt_irq_i,
   input logic [N-1:0] req_i,
   input logic [N-1:0] mask_i,
   input logic         cpu_clk_en_o,
   input logic         branch_o,
   input logic         resume_o,
   input logic         ack_nmi_o
);

   logic nmi_any;
   logic wake_src;
   logic pulse;

   assign nmi_any  = nmi_pin_i | wdt_irq_i;
   assign wake_src = nmi_any | (|(req_i & ~mask_i));
   assign pulse    = branch_o | resume_o;

   AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_int_n)
      (cpu_clk_en_o && !pulse && halt_req_i) |=> !cpu_clk_en_o); // R1

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!cpu_clk_en_o && !wake_src) |=> (!cpu_clk_en_o && !pulse)); // R2

   AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!cpu_clk_en_o && wake_src) |=> (cpu_clk_en_o && pulse)); // R3

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
      $onehot0({branch_o, resume_o})); // R3

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
      pulse |=> !pulse); // R3

   AST_NMI_BRANCH: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!cpu_clk_en_o && nmi_any) |=> (branch_o && ack_nmi_o)); // R4

   AST_WAKE_IGNORES_HALT: assert property (@(posedge clk) disable iff (!rst_int_n)
      (pulse && halt_req_i) |=> cpu_clk_en_o); // R12

endmodule

bind halt_wake_ctrl hwc_checker #(
   .N (NUM_EXT + NUM_PERIPH)
) u_chk (
   .clk          (clk),
   .rst_int_n    (rst_int_n),
   .halt_req_i   (halt_req_i),
   .nmi_pin_i    (nmi_pin_i),
   .wdt_irq_i    (wdt_irq_i),
   .req_i        (all_req),
   .mask_i       (all_mask),
   .cpu_clk_en_o (cpu_clk_en_o),
   .branch_o     (branch_o),
   .resume_o     (resume_o),
   .ack_nmi_o    (ack_nmi_o)
);

// File: tb/halt_wake_ctrl_test.sv
module halt_wake_ctrl_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n_i = 1'b0;
   logic [2:0]  rst_src_i = '0;
   logic        halt_req_i = 1'b0;
   logic        nmi_pin_i = 1'b0;
   logic        wdt_irq_i = 1'b0;
   logic [7:0]  ext_req_i = '0;
   logic [7:0]  ext_mask_i = '0;
   logic [23:0] ext_prio_i;
   logic [7:0]  per_req_i = '0;
   logic [7:0]  per_mask_i = '0;
   logic [23:0] per_prio_i;
   logic        in_service_i = 1'b0;
   logic [2:0]  in_service_lvl_i = '0;
   logic        int_en_i = 1'b1;
   logic        cpu_clk_en_o, branch_o, resume_o, ack_o, ack_nmi_o;
   logic [3:0]  ack_idx_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   halt_wake_ctrl uut (
      .clk(clk), .rst_n_i(rst_n_i), .rst_src_i(rst_src_i), .halt_req_i(halt_req_i),
      .nmi_pin_i(nmi_pin_i), .wdt_irq_i(wdt_irq_i),
      .ext_req_i(ext_req_i), .ext_mask_i(ext_mask_i), .ext_prio_i(ext_prio_i),
      .per_req_i(per_req_i), .per_mask_i(per_mask_i), .per_prio_i(per_prio_i),
      .in_service_i(in_service_i), .in_service_lvl_i(in_service_lvl_i), .int_en_i(int_en_i),
      .cpu_clk_en_o(cpu_clk_en_o), .branch_o(branch_o), .resume_o(resume_o),
      .ack_o(ack_o), .ack_nmi_o(ack_nmi_o), .ack_idx_o(ack_idx_o)
   );

   // priority of line i (ext 0..7, periph 8..15) is 7 - (i % 8)
   initial begin
      for (int i = 0; i < 8; i++) begin
         ext_prio_i[i*3 +: 3] = 3'(7 - i);
         per_prio_i[i*3 +: 3] = 3'(7 - i);
      end
   end

   typedef struct packed {
      logic        nmi;
      logic        wdt;
      logic [15:0] req;
      logic [15:0] msk;
      logic        isr;
      logic [2:0]  lvl;
      logic        ie;
      logic        eb;
      logic        ea;
      logic        en;
      logic [3:0]  eidx;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 16'h0001, 16'h0000, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0},  // R9 prio 7 idle
      '{1'b0, 1'b0, 16'h0008, 16'h0000, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R6 equal level
      '{1'b0, 1'b0, 16'h0008, 16'h0000, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R5 above level
      '{1'b0, 1'b0, 16'h0400, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},  // R7 disabled
      '{1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0},  // R4 pin
      '{1'b0, 1'b1, 16'h0080, 16'h0000, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0},  // R4 watchdog
      '{1'b0, 1'b0, 16'h8080, 16'h0000, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7},  // R8 tie
      '{1'b0, 1'b0, 16'h1006, 16'h0000, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd12}, // R8 best
      '{1'b0, 1'b0, 16'h0024, 16'h0020, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R8 masked skip
      '{1'b0, 1'b0, 16'h8000, 16'h0000, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R6 level 0
      '{1'b0, 1'b0, 16'h0200, 16'h0000, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 4'd9}   // R5 periph
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_reqs();
      nmi_pin_i = 0; wdt_irq_i = 0;
      ext_req_i = '0; per_req_i = '0; ext_mask_i = '0; per_mask_i = '0;
      in_service_i = 0; in_service_lvl_i = '0; int_en_i = 1;
   endtask

   task automatic enter_halt();
      halt_req_i = 1;
      step();
      halt_req_i = 0;
   endtask

   function automatic logic [7:0] outs();
      return {2'b00, cpu_clk_en_o, branch_o, resume_o, ack_o, ack_nmi_o, 1'b0};
   endfunction

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected<=20000", cycles);
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      // R11 reset state while the pin is low
      chk("R11 reset clk_en/pulses", outs(), 8'b0010_0000);
      step(); step();
      rst_n_i = 1;
      step(); step();
      chk("R11 run after release", outs(), 8'b0010_0000);

      // table walk
      for (int v = 0; v < NV; v++) begin
         clear_reqs();
         enter_halt();
         chk("R1 halted clk_en", {7'd0, cpu_clk_en_o}, 8'd0);
         nmi_pin_i = VEC[v].nmi; wdt_irq_i = VEC[v].wdt;
         ext_req_i = VEC[v].req[7:0]; per_req_i = VEC[v].req[15:8];
         ext_mask_i = VEC[v].msk[7:0]; per_mask_i = VEC[v].msk[15:8];
         in_service_i = VEC[v].isr; in_service_lvl_i = VEC[v].lvl; int_en_i = VEC[v].ie;
         step();
         chk($sformatf("R3/R4-R9 wake outs v%0d", v), outs(),
             {2'b00, 1'b1, VEC[v].eb, ~VEC[v].eb, VEC[v].ea, VEC[v].en, 1'b0});
         chk($sformatf("R5/R8 ack_idx v%0d", v), {4'd0, ack_idx_o}, {4'd0, VEC[v].eidx});
         clear_reqs();
         step();
         chk($sformatf("R3 back to run v%0d", v), outs(), 8'b0010_0000);
      end

      // R2 masked request and silence keep halt; R12 halt_req in halt ignored
      clear_reqs();
      enter_halt();
      ext_req_i = 8'h10; ext_mask_i = 8'h10;
      per_req_i = 8'h01; per_mask_i = 8'h01;
      step(); step();
      chk("R2 masked stays halted", outs(), 8'b0000_0000);
      halt_req_i = 1;
      step();
      halt_req_i = 0;
      chk("R12 halt_req in halt", outs(), 8'b0000_0000);
      ext_mask_i = 8'h00;
      halt_req_i = 1;
      step();
      chk("R3 unmasked ext4 wakes", outs(), 8'b0011_0100);
      chk("R3 idx ext4", {4'd0, ack_idx_o}, 8'd4);
      // halt_req still high during wake cycle: R12
      step();
      halt_req_i = 0;
      clear_reqs();
      chk("R12 halt_req in wake ignored", outs(), 8'b0010_0000);
      step();
      chk("R12 still running", outs(), 8'b0010_0000);

      // R10 request pending before the halt request
      clear_reqs();
      per_req_i = 8'h04;
      halt_req_i = 1;
      step();
      halt_req_i = 0;
      chk("R10 one halted cycle", outs(), 8'b0000_0000);
      step();
      chk("R10 wakes at once", outs(), 8'b0011_0100);
      chk("R10 idx periph2", {4'd0, ack_idx_o}, 8'd10);
      clear_reqs();
      step();

      // R11 secondary reset source during halt
      enter_halt();
      chk("R11 pre halted", {7'd0, cpu_clk_en_o}, 8'd0);
      rst_src_i = 3'b010;
      #1;
      chk("R11 source forces run", outs(), 8'b0010_0000);
      @(negedge clk);
      rst_src_i = '0;
      ext_req_i = 8'h01;  // wake source present while in reset has no effect
      halt_req_i = 1;
      step();
      halt_req_i = 0;
      chk("R11 held one edge after release", outs(), 8'b0010_0000);
      step();
      halt_req_i = 1;
      step();
      halt_req_i = 0;
      chk("R11 halts after sync release", outs(), 8'b0000_0000);
      step();
      chk("R11 then wakes normally", outs(), 8'b0011_0100);
      clear_reqs();
      step();

      finish_run();
   end

endmodule